// File: doc/BRIEF.md
# Latency-Aware Issue Interlock

This block sits at the decode/issue point of an in-order, single-issue pipeline that has an integer register file and a floating-point register file. It remembers which registers are still waiting on a result from an instruction already issued. For each instruction at decode, it compares that instruction's sources against those waiting registers. It then holds the instruction back for exactly as many cycles as the producing and consuming instruction kinds require.

The required gap is not a fixed single cycle. It is read from a table indexed by the producer's class and by the role in which the consumer reads the register. That role can be an integer operand, a floating-point operand, store data, or a branch test. Branches get their own penalty because no forwarding path reaches the branch compare. Only read-after-write dependences stall. Issue and writeback stay in program order, so write-after-read and write-after-write never hold issue.

Each register has a small countdown that is loaded when a producer issues and that drains by one each cycle. The consumer waits until enough cycles have passed since the producer issued. While it waits, the pipeline inserts a bubble behind it and the stalled instruction records nothing.

Top module: `ilk_interlock`

## Requirements
- R1: A synchronous active-high `rst` clears every pending register. In the cycle after a reset cycle `stall` is 0, and a consumer of a register written before the reset issues with no stall.
- R2: An FP ALU result (class 2) read as an operand by a following FP ALU instruction, through either source, costs 3 stall cycles when the two are adjacent.
- R3: An FP ALU result read as store data (class 4, source B with `srcBFp`=1) costs 2 stall cycles when adjacent.
- R4: A load result (class 3, floating-point destination) read by an FP ALU instruction costs 1 stall cycle when adjacent.
- R5: A load result read as store data costs no stall.
- R6: An integer ALU result (class 1) read by a following integer ALU instruction costs no stall.
- R7: An integer result tested by a branch (class 5, source A) costs 1 stall cycle when adjacent.
- R8: Integer register 0 never creates or matches a pending write.
- R9: `issue` equals `instValid` and not `stall`, and `stall` is only ever 1 with `instValid`=1. An instruction does not create its pending write while it is stalled. Its countdown starts in the cycle it issues.
- R10: Every cycle that passes after the producer issues counts toward the gap, including independent instructions and empty cycles. With k such cycles between producer and consumer, the stall is the table value minus k, floored at 0.
- R11: A source matches only a register in the same file with the same index. A destination that matches a pending register, with no source match, does not stall (no WAR/WAW interlock).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instValid | input | 1 | An instruction is present at decode |
| instClass | input | 3 | Class: 0 none, 1 integer ALU, 2 FP ALU, 3 FP load, 4 FP store, 5 branch |
| dstValid | input | 1 | Instruction writes a register |
| dstFp | input | 1 | Destination is in the floating-point file |
| dstIdx | input | REG_W | Destination register index |
| srcAValid | input | 1 | Source A is read |
| srcAFp | input | 1 | Source A is in the floating-point file |
| srcAIdx | input | REG_W | Source A index (address for load/store, test register for branch) |
| srcBValid | input | 1 | Source B is read |
| srcBFp | input | 1 | Source B is in the floating-point file |
| srcBIdx | input | REG_W | Source B index (data for store) |
| stall | output | 1 | Hold the decode instruction and insert a bubble |
| issue | output | 1 | The decode instruction leaves decode this cycle |

## Verification
Suppose a countdown is loaded with the wrong value, starts in the wrong cycle, or is written during a stall. Then the next dependent instruction stalls a different number of cycles than the table gives. That shows at `stall` within at most three cycles of the producer's issue. The bench therefore measures stall lengths across every producer/consumer pairing and every separation from zero up to past the longest gap. A pending entry that fails to clear, or that matches the wrong file or register 0, shows as a spurious stall on the very next instruction that reads that name.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  localparam int CNT_W = 2;

  typedef enum logic [2:0] {
    CLS_NONE   = 3'd0,
    CLS_INT    = 3'd1,
    CLS_FPALU  = 3'd2,
    CLS_LOAD   = 3'd3,
    CLS_STORE  = 3'd4,
    CLS_BRANCH = 3'd5
  } ilk_class_e;

  typedef enum logic [2:0] {
    USE_NONE   = 3'd0,
    USE_INT    = 3'd1,
    USE_FP     = 3'd2,
    USE_STDATA = 3'd3,
    USE_BR     = 3'd4
  } ilk_use_e;

  typedef struct packed {
    logic issue;
    logic record;
  } ilk_strobe_t;

  // Cycles a producer's entry stays live: the longest gap any consumer needs.
  function automatic logic [CNT_W-1:0] holdCycles(input ilk_class_e cls);
    case (cls)
      CLS_FPALU: holdCycles = CNT_W'(3);
      CLS_LOAD:  holdCycles = CNT_W'(1);
      CLS_INT:   holdCycles = CNT_W'(1);
      default:   holdCycles = '0;
    endcase
  endfunction

  // Stall cycles needed between an adjacent producer and consumer.
  function automatic logic [CNT_W-1:0] gapNeed(input ilk_class_e prod, input ilk_use_e use_);
    gapNeed = '0;
    case (prod)
      CLS_FPALU: begin
        if (use_ == USE_FP)     gapNeed = CNT_W'(3);
        if (use_ == USE_STDATA) gapNeed = CNT_W'(2);
      end
      CLS_LOAD:  if (use_ == USE_FP) gapNeed = CNT_W'(1);
      CLS_INT:   if (use_ == USE_BR) gapNeed = CNT_W'(1);
      default:   gapNeed = '0;
    endcase
  endfunction

  function automatic ilk_use_e useOfA(input ilk_class_e cls);
    case (cls)
      CLS_INT, CLS_LOAD, CLS_STORE: useOfA = USE_INT;
      CLS_FPALU:                    useOfA = USE_FP;
      CLS_BRANCH:                   useOfA = USE_BR;
      default:                      useOfA = USE_NONE;
    endcase
  endfunction

  function automatic ilk_use_e useOfB(input ilk_class_e cls);
    case (cls)
      CLS_INT:   useOfB = USE_INT;
      CLS_FPALU: useOfB = USE_FP;
      CLS_STORE: useOfB = USE_STDATA;
      default:   useOfB = USE_NONE;
    endcase
  endfunction

endpackage

// File: rtl/ilk_scoreboard.sv
module ilk_scoreboard
  import ilk_pkg::*;
#(
  parameter int NUM_REGS = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  ilk_strobe_t              strobe,
  input  ilk_class_e               dstClass,
  input  logic                     dstFp,
  input  logic [$clog2(NUM_REGS)-1:0] dstIdx,
  input  logic                     srcAFp,
  input  logic [$clog2(NUM_REGS)-1:0] srcAIdx,
  input  logic                     srcBFp,
  input  logic [$clog2(NUM_REGS)-1:0] srcBIdx,
  output logic [CNT_W-1:0]         aRem,
  output ilk_class_e               aCls,
  output logic [CNT_W-1:0]         bRem,
  output ilk_class_e               bCls
);
  localparam int REG_W   = $clog2(NUM_REGS);
  localparam int ENTRIES = 2 * NUM_REGS;
  localparam int SEL_W   = REG_W + 1;

  logic [CNT_W-1:0] remTab [ENTRIES];
  ilk_class_e       clsTab [ENTRIES];

  logic [SEL_W-1:0] dstSel, aSel, bSel;
  assign dstSel = {dstFp, dstIdx};
  assign aSel   = {srcAFp, srcAIdx};
  assign bSel   = {srcBFp, srcBIdx};

  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (rst) begin
        remTab[g] <= '0;
        clsTab[g] <= CLS_NONE;
      end else if (strobe.record && dstSel == SEL_W'(g)) begin
        remTab[g] <= holdCycles(dstClass);
        clsTab[g] <= dstClass;
      end else if (remTab[g] != '0) begin
        remTab[g] <= remTab[g] - 1'b1;
      end
    end
  end

  assign aRem = remTab[aSel];
  assign aCls = clsTab[aSel];
  assign bRem = remTab[bSel];
  assign bCls = clsTab[bSel];

endmodule

// File: rtl/ilk_control.sv
module ilk_control
  import ilk_pkg::*;
#(
  parameter int NUM_REGS = 32
) (
  input  logic                        instValid,
  input  ilk_class_e                  instClass,
  input  logic                        dstValid,
  input  logic                        dstFp,
  input  logic [$clog2(NUM_REGS)-1:0] dstIdx,
  input  logic                        srcAValid,
  input  logic                        srcAFp,
  input  logic [$clog2(NUM_REGS)-1:0] srcAIdx,
  input  logic                        srcBValid,
  input  logic                        srcBFp,
  input  logic [$clog2(NUM_REGS)-1:0] srcBIdx,
  input  logic [CNT_W-1:0]            aRem,
  input  ilk_class_e                  aCls,
  input  logic [CNT_W-1:0]            bRem,
  input  ilk_class_e                  bCls,
  output logic                        stall,
  output ilk_strobe_t                 strobe
);
  logic aReal, bReal, dstReal;
  logic hazA, hazB;
  logic [CNT_W:0] aSum, bSum;

  // Integer register 0 is hard-wired and never carries a dependence.
  assign aReal   = srcAValid && (srcAFp || srcAIdx != '0);
  assign bReal   = srcBValid && (srcBFp || srcBIdx != '0);
  assign dstReal = dstValid  && (dstFp  || dstIdx  != '0);

  // Waiting while elapsed (hold - rem) is below the need, i.e. rem + need > hold.
  assign aSum = {1'b0, aRem} + {1'b0, gapNeed(aCls, useOfA(instClass))};
  assign bSum = {1'b0, bRem} + {1'b0, gapNeed(bCls, useOfB(instClass))};

  assign hazA = aReal && (aRem != '0) && (aSum > {1'b0, holdCycles(aCls)});
  assign hazB = bReal && (bRem != '0) && (bSum > {1'b0, holdCycles(bCls)});

  assign stall         = instValid && (hazA || hazB);
  assign strobe.issue  = instValid && !stall;
  assign strobe.record = strobe.issue && dstReal && (holdCycles(instClass) != '0);

endmodule

// File: rtl/ilk_interlock.sv
module ilk_interlock
  import ilk_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instValid,
  input  logic [2:0]       instClass,
  input  logic             dstValid,
  input  logic             dstFp,
  input  logic [REG_W-1:0] dstIdx,
  input  logic             srcAValid,
  input  logic             srcAFp,
  input  logic [REG_W-1:0] srcAIdx,
  input  logic             srcBValid,
  input  logic             srcBFp,
  input  logic [REG_W-1:0] srcBIdx,
  output logic             stall,
  output logic             issue
);
  ilk_class_e       cls;
  ilk_strobe_t      strobe;
  logic [CNT_W-1:0] aRem, bRem;
  ilk_class_e       aCls, bCls;

  assign cls   = ilk_class_e'(instClass);
  assign issue = strobe.issue;

  ilk_control #(.NUM_REGS(NUM_REGS)) u_ctrl (
    .instValid(instValid), .instClass(cls),
    .dstValid(dstValid), .dstFp(dstFp), .dstIdx(dstIdx),
    .srcAValid(srcAValid), .srcAFp(srcAFp), .srcAIdx(srcAIdx),
    .srcBValid(srcBValid), .srcBFp(srcBFp), .srcBIdx(srcBIdx),
    .aRem(aRem), .aCls(aCls), .bRem(bRem), .bCls(bCls),
    .stall(stall), .strobe(strobe)
  );

  ilk_scoreboard #(.NUM_REGS(NUM_REGS)) u_sb (
    .clk(clk), .rst(rst), .strobe(strobe), .dstClass(cls),
    .dstFp(dstFp), .dstIdx(dstIdx),
    .srcAFp(srcAFp), .srcAIdx(srcAIdx),
    .srcBFp(srcBFp), .srcBIdx(srcBIdx),
    .aRem(aRem), .aCls(aCls), .bRem(bRem), .bCls(bCls)
  );

endmodule

// File: rtl/ilk_checker.sv
module ilk_checker #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             instValid,
  input logic [2:0]       instClass,
  input logic             dstValid,
  input logic             dstFp,
  input logic [REG_W-1:0] dstIdx,
  input logic             srcAValid,
  input logic             srcAFp,
  input logic [REG_W-1:0] srcAIdx,
  input logic             srcBValid,
  input logic             srcBFp,
  input logic [REG_W-1:0] srcBIdx,
  input logic             stall,
  input logic             issue
);
  p_reset_clears_r1: assert property (@(posedge clk) rst |=> !stall);

  p_issue_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(issue && stall) && (issue == (instValid && !stall)));

  p_stall_needs_inst_r9: assert property (@(posedge clk) disable iff (rst)
    stall |-> instValid);

  p_fp_chain_r2: assert property (@(posedge clk) disable iff (rst)
    (issue && instClass == 3'd2 && dstValid && dstFp) |=>
      (!(instValid && instClass == 3'd2 && srcAValid && srcAFp &&
         srcAIdx == $past(dstIdx)) || stall));

  p_load_to_store_r5: assert property (@(posedge clk) disable iff (rst)
    (issue && instClass == 3'd3 && dstValid && dstFp) |=>
      (!(instValid && instClass == 3'd4 && !srcAValid && srcBValid && srcBFp &&
         srcBIdx == $past(dstIdx)) || !stall));

  p_int_to_branch_r7: assert property (@(posedge clk) disable iff (rst)
    (issue && instClass == 3'd1 && dstValid && !dstFp && dstIdx != '0) |=>
      (!(instValid && instClass == 3'd5 && srcAValid && !srcAFp &&
         srcAIdx == $past(dstIdx) && !srcBValid) || stall));

  p_reg_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (instValid && srcAValid && !srcAFp && srcAIdx == '0 &&
     (!srcBValid || (!srcBFp && srcBIdx == '0))) |-> !stall);

endmodule

bind ilk_interlock ilk_checker #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .instValid(instValid), .instClass(instClass),
  .dstValid(dstValid), .dstFp(dstFp), .dstIdx(dstIdx),
  .srcAValid(srcAValid), .srcAFp(srcAFp), .srcAIdx(srcAIdx),
  .srcBValid(srcBValid), .srcBFp(srcBFp), .srcBIdx(srcBIdx),
  .stall(stall), .issue(issue)
);

// File: tb/sim_ilk_interlock.sv
`timescale 1ns/1ps
module sim_ilk_interlock;
  localparam int REG_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic instValid = 1'b0;
  logic [2:0] instClass = '0;
  logic dstValid = 1'b0, dstFp = 1'b0;
  logic [REG_W-1:0] dstIdx = '0;
  logic srcAValid = 1'b0, srcAFp = 1'b0;
  logic [REG_W-1:0] srcAIdx = '0;
  logic srcBValid = 1'b0, srcBFp = 1'b0;
  logic [REG_W-1:0] srcBIdx = '0;
  logic stall, issue;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  ilk_interlock #(.NUM_REGS(32)) u0 (
    .clk(clk), .rst(rst), .instValid(instValid), .instClass(instClass),
    .dstValid(dstValid), .dstFp(dstFp), .dstIdx(dstIdx),
    .srcAValid(srcAValid), .srcAFp(srcAFp), .srcAIdx(srcAIdx),
    .srcBValid(srcBValid), .srcBFp(srcBFp), .srcBIdx(srcBIdx),
    .stall(stall), .issue(issue)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Present one instruction, count its stall cycles until it issues.
  task automatic send(input int cls, input bit dv, input bit dfp, input int di,
                      input bit av, input bit afp, input int ai,
                      input bit bv, input bit bfp, input int bi, output int stalls);
    stalls = 0;
    @(negedge clk);
    instValid = 1'b1; instClass = 3'(cls);
    dstValid = dv; dstFp = dfp; dstIdx = REG_W'(di);
    srcAValid = av; srcAFp = afp; srcAIdx = REG_W'(ai);
    srcBValid = bv; srcBFp = bfp; srcBIdx = REG_W'(bi);
    #1;
    while (stall && stalls < 20) begin
      check(issue == 1'b0, "R9 issue low while stalled", int'(issue), 0);
      stalls++;
      @(negedge clk); #1;
    end
    check(issue == 1'b1, "R9 issue when not stalled", int'(issue), 1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      instValid = 1'b0; dstValid = 1'b0; srcAValid = 1'b0; srcBValid = 1'b0;
    end
  endtask

  task automatic filler();
    int s;
    send(1, 1'b1, 1'b0, 30, 1'b0, 1'b0, 0, 1'b0, 1'b0, 0, s);
  endtask

  // Expected stall cycles for an adjacent pair: pair 0 fp->fp, 1 fp->stdata,
  // 2 load->fp, 3 load->stdata, 4 int->int, 5 int->branch.
  function automatic int tableGap(input int pair);
    case (pair)
      0: return 3;
      1: return 2;
      2: return 1;
      3: return 0;
      4: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic string pairReq(input int pair);
    case (pair)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    repeat (300000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int s;
    int exp;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check(stall == 1'b0 && issue == 1'b0, "R1 outputs idle in reset", int'(stall), 0);
    rst = 1'b0;

    // R1: pending write dropped by reset
    send(2, 1'b1, 1'b1, 1, 1'b0, 1'b0, 0, 1'b0, 1'b0, 0, s);
    @(negedge clk); instValid = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    send(2, 1'b1, 1'b1, 2, 1'b1, 1'b1, 1, 1'b0, 1'b0, 0, s);
    check(s == 0, "R1 consumer after reset", s, 0);
    idle(4);

    // R2..R7, R10: sweep pairs and separations
    for (int pair = 0; pair < 6; pair++) begin
      for (int k = 0; k < 5; k++) begin
        case (pair)
          0, 1: send(2, 1'b1, 1'b1, 1, 1'b1, 1'b1, 6, 1'b1, 1'b1, 7, s);
          2, 3: send(3, 1'b1, 1'b1, 1, 1'b1, 1'b0, 5, 1'b0, 1'b0, 0, s);
          default: send(1, 1'b1, 1'b0, 3, 1'b1, 1'b0, 8, 1'b0, 1'b0, 0, s);
        endcase
        for (int f = 0; f < k; f++) begin
          if (f % 2 == 0) filler(); else idle(1);
        end
        case (pair)
          0, 2: begin
            if (k % 2 == 0) send(2, 1'b1, 1'b1, 9, 1'b1, 1'b1, 1, 1'b0, 1'b0, 0, s);
            else            send(2, 1'b1, 1'b1, 9, 1'b1, 1'b1, 6, 1'b1, 1'b1, 1, s);
          end
          1, 3: send(4, 1'b0, 1'b0, 0, 1'b1, 1'b0, 5, 1'b1, 1'b1, 1, s);
          4: send(1, 1'b1, 1'b0, 4, 1'b1, 1'b0, 3, 1'b1, 1'b0, 8, s);
          default: send(5, 1'b0, 1'b0, 0, 1'b1, 1'b0, 3, 1'b0, 1'b0, 0, s);
        endcase
        exp = tableGap(pair) - k;
        if (exp < 0) exp = 0;
        check(s == exp, $sformatf("%s gap %0d (R10)", pairReq(pair), k), s, exp);
        idle(4);
      end
    end

    // R8: integer register 0 never pending
    send(1, 1'b1, 1'b0, 0, 1'b0, 1'b0, 0, 1'b0, 1'b0, 0, s);
    send(5, 1'b0, 1'b0, 0, 1'b1, 1'b0, 0, 1'b0, 1'b0, 0, s);
    check(s == 0, "R8 branch on r0 after write to r0", s, 0);
    idle(4);

    // R9: stalled instruction records nothing until it issues
    send(2, 1'b1, 1'b1, 1, 1'b0, 1'b0, 0, 1'b0, 1'b0, 0, s);
    send(2, 1'b1, 1'b1, 2, 1'b1, 1'b1, 1, 1'b0, 1'b0, 0, s);
    check(s == 3, "R9 first of chain", s, 3);
    send(2, 1'b1, 1'b1, 10, 1'b1, 1'b1, 2, 1'b0, 1'b0, 0, s);
    check(s == 3, "R9 countdown starts at issue", s, 3);
    idle(4);

    // R9: no stall without a valid instruction
    send(2, 1'b1, 1'b1, 1, 1'b0, 1'b0, 0, 1'b0, 1'b0, 0, s);
    @(negedge clk);
    instValid = 1'b0; instClass = 3'd2; srcAValid = 1'b1; srcAFp = 1'b1; srcAIdx = 5'd1;
    #1;
    check(stall == 1'b0 && issue == 1'b0, "R9 stall needs valid", int'(stall), 0);
    idle(4);

    // R11: other file, same index -> no match
    send(2, 1'b1, 1'b1, 4, 1'b0, 1'b0, 0, 1'b0, 1'b0, 0, s);
    send(5, 1'b0, 1'b0, 0, 1'b1, 1'b0, 4, 1'b0, 1'b0, 0, s);
    check(s == 0, "R11 file mismatch", s, 0);
    idle(4);

    // R11: write-after-write and write-after-read do not stall
    send(2, 1'b1, 1'b1, 1, 1'b1, 1'b1, 12, 1'b0, 1'b0, 0, s);
    send(2, 1'b1, 1'b1, 1, 1'b1, 1'b1, 6, 1'b0, 1'b0, 0, s);
    check(s == 0, "R11 WAW", s, 0);
    send(2, 1'b1, 1'b1, 12, 1'b1, 1'b1, 7, 1'b0, 1'b0, 0, s);
    check(s == 0, "R11 WAR", s, 0);
    idle(4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule